// File: doc/BRIEF.md
# Pipelined Weighted-Sum Threshold Comparator

This block decides, once per clock, whether the weighted count of a 5x5 grid of one-bit selection flags reaches a programmable threshold. Each grid cell holds an unsigned integer weight. A weight counts toward the total only when its flag is set. The block first adds the gated weights of each row in a small per-row tree. A column tree then adds the row totals. The result is compared with the threshold by adding the threshold's two's complement and reading the carry-out of that adder.

Registers sit between the row level, the column level and the compare. A fresh flag set and threshold can therefore be presented on every clock, and each answer comes out three clocks later with its own valid strobe. The weights are programmed serially. They shift through a chain of cell registers, one weight per clock, while the load enable is high. The block is intended as the inner step of a bit-serial weighted rank-order search. In that use, the surrounding logic supplies the flags and the threshold.

Top module: `wsc_threshold_cmp`

## Requirements
- R1: After reset, outValid and geThreshold are 0 and every weight cell holds 1.
- R2: For an accepted input, geThreshold is 1 exactly when the sum of the weights of all cells whose flag is set is greater than or equal to threshold. Flag bit r*5+c belongs to row r, column c. A set with no flag set and a nonzero threshold gives 0.
- R3: outValid is high exactly on the third clock after a clock that sampled inValid high. Its result appears after three register stages.
- R4: Inputs may be accepted on consecutive clocks, and every one of them yields its own result in order.
- R5: While outValid is low, geThreshold keeps the value of the last result.
- R6: A threshold of 0 always yields geThreshold = 1.
- R7: While loadEn is high, each clock shifts loadWeight into cell 24, and every cell i takes the old value of cell i+1. After 25 loads, the first weight loaded sits in cell 0, which is row 0, column 0.
- R8: While loadEn is low, loadWeight has no effect and the weights stay unchanged.
- R9: At the boundary, a sum equal to threshold gives 1 and a sum one below threshold gives 0.
- R10: A weight total of up to 255 is compared without loss. With all 25 flags set, a total of 255 against a threshold of 255 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Shift one weight into the chain this clock |
| loadWeight | input | 8 | Serial weight value entering cell 24 |
| inValid | input | 1 | flags and threshold are valid this clock |
| flags | input | 25 | Selection flag per cell, bit r*5+c |
| threshold | input | 8 | Threshold the weighted sum is compared with |
| outValid | output | 1 | geThreshold carries a fresh result |
| geThreshold | output | 1 | 1 when the weighted sum reaches threshold |

## Verification
The hardest cases to reach from the ports are the exact boundary, where the sum equals the threshold or falls one short of it, and the largest legal total of 255. Random flags almost never land on these cases. The stimulus reaches them by computing the current weighted sum in the bench and setting the threshold to that sum and to the sum plus one. It also loads a weight set whose total is exactly 255. The cell order of the serial chain is confirmed by probing each cell alone with a single set flag. In that probe, the threshold is set to the cell's own weight and then one above it.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  // Strobes from the control to the datapath, one per pipeline step.
  typedef struct packed {
    logic shift;   // advance the weight chain
    logic stage1;  // capture row sums and threshold
    logic stage2;  // capture column sum
    logic stage3;  // capture compare result
  } wscStrobes_t;
endpackage

// File: rtl/wsc_weight_chain.sv
module wsc_weight_chain #(
  parameter int CELLS = 25,
  parameter int WGT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift,
  input  logic [WGT_W-1:0]       serialIn,
  output logic [CELLS*WGT_W-1:0] weightsFlat
);
  logic [WGT_W-1:0] cellQ [CELLS];

  generate
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
      logic [WGT_W-1:0] nextVal;
      if (i == CELLS - 1) begin : g_head
        assign nextVal = serialIn;
      end else begin : g_body
        assign nextVal = cellQ[i+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cellQ[i] <= WGT_W'(1);
        else if (shift) cellQ[i] <= nextVal;
      end
      assign weightsFlat[i*WGT_W +: WGT_W] = cellQ[i];
    end
  endgenerate
endmodule

// File: rtl/wsc_row_tree.sv
module wsc_row_tree #(
  parameter int COLS  = 5,
  parameter int WGT_W = 8,
  parameter int SUM_W = 8
) (
  input  logic [COLS*WGT_W-1:0] rowWeights,
  input  logic [COLS-1:0]       rowFlags,
  output logic [SUM_W-1:0]      rowSum
);
  logic [SUM_W-1:0] gated [COLS];

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_gate
      assign gated[c] = rowFlags[c] ? SUM_W'(rowWeights[c*WGT_W +: WGT_W]) : '0;
    end
  endgenerate

  always_comb begin
    rowSum = '0;
    for (int c = 0; c < COLS; c++) rowSum = rowSum + gated[c];
  end
endmodule

// File: rtl/wsc_control.sv
module wsc_control
  import wsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        loadEn,
  output wscStrobes_t strobes,
  output logic        outValid
);
  logic vld1, vld2, vld3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1 <= 1'b0;
      vld2 <= 1'b0;
      vld3 <= 1'b0;
    end else begin
      vld1 <= inValid;
      vld2 <= vld1;
      vld3 <= vld2;
    end
  end

  always_comb begin
    strobes.shift  = loadEn;
    strobes.stage1 = inValid;
    strobes.stage2 = vld1;
    strobes.stage3 = vld2;
  end

  assign outValid = vld3;
endmodule

// File: rtl/wsc_datapath.sv
module wsc_datapath
  import wsc_pkg::*;
#(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int WGT_W = 8,
  parameter int SUM_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wscStrobes_t          strobes,
  input  logic [WGT_W-1:0]     loadWeight,
  input  logic [ROWS*COLS-1:0] flags,
  input  logic [SUM_W-1:0]     threshold,
  output logic                 geThreshold
);
  localparam int CELLS = ROWS * COLS;

  logic [CELLS*WGT_W-1:0] weightsFlat;
  logic [SUM_W-1:0]       rowSumD [ROWS];
  logic [SUM_W-1:0]       rowSumQ [ROWS];
  logic [SUM_W-1:0]       thrQ1, thrQ2;
  logic [SUM_W-1:0]       colSumD, colSumQ;
  logic [SUM_W:0]         cmpSum;

  wsc_weight_chain #(.CELLS(CELLS), .WGT_W(WGT_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift(strobes.shift),
    .serialIn(loadWeight), .weightsFlat(weightsFlat)
  );

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      wsc_row_tree #(.COLS(COLS), .WGT_W(WGT_W), .SUM_W(SUM_W)) u_row (
        .rowWeights(weightsFlat[r*COLS*WGT_W +: COLS*WGT_W]),
        .rowFlags(flags[r*COLS +: COLS]),
        .rowSum(rowSumD[r])
      );
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              rowSumQ[r] <= '0;
        else if (strobes.stage1) rowSumQ[r] <= rowSumD[r];
      end
    end
  endgenerate

  // Column tree over the registered row totals.
  always_comb begin
    colSumD = '0;
    for (int r = 0; r < ROWS; r++) colSumD = colSumD + rowSumQ[r];
  end

  // Add the two's complement of the threshold; the carry means sum >= threshold.
  assign cmpSum = {1'b0, colSumQ} + {1'b0, ~thrQ2} + {{SUM_W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thrQ1       <= '0;
      thrQ2       <= '0;
      colSumQ     <= '0;
      geThreshold <= 1'b0;
    end else begin
      if (strobes.stage1) thrQ1 <= threshold;
      if (strobes.stage2) begin
        colSumQ <= colSumD;
        thrQ2   <= thrQ1;
      end
      if (strobes.stage3) geThreshold <= cmpSum[SUM_W];
    end
  end
endmodule

// File: rtl/wsc_threshold_cmp.sv
module wsc_threshold_cmp
  import wsc_pkg::*;
#(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int WGT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 loadEn,
  input  logic [WGT_W-1:0]     loadWeight,
  input  logic                 inValid,
  input  logic [ROWS*COLS-1:0] flags,
  input  logic [WGT_W-1:0]     threshold,
  output logic                 outValid,
  output logic                 geThreshold
);
  localparam int SUM_W = WGT_W;

  wscStrobes_t strobes;

  wsc_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .loadEn(loadEn),
    .strobes(strobes), .outValid(outValid)
  );

  wsc_datapath #(.ROWS(ROWS), .COLS(COLS), .WGT_W(WGT_W), .SUM_W(SUM_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .loadWeight(loadWeight),
    .flags(flags), .threshold(threshold), .geThreshold(geThreshold)
  );
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
  parameter int FLAG_W = 25,
  parameter int THR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [FLAG_W-1:0] flags,
  input logic [THR_W-1:0]  threshold,
  input logic              outValid,
  input logic              geThreshold
);
  logic [1:0] age;
  logic [2:0] zeroThrPipe;
  logic [2:0] emptyPipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age         <= '0;
      zeroThrPipe <= '0;
      emptyPipe   <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      zeroThrPipe <= {zeroThrPipe[1:0], inValid && (threshold == '0)};
      emptyPipe   <= {emptyPipe[1:0], inValid && (flags == '0) && (threshold != '0)};
    end
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (outValid == $past(inValid, 3)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((age != 2'd0) && !outValid) |-> $stable(geThreshold));

  assert_zero_thr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && zeroThrPipe[2]) |-> geThreshold);

  assert_empty_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && emptyPipe[2]) |-> !geThreshold);
endmodule

bind wsc_threshold_cmp wsc_checker #(.FLAG_W(ROWS*COLS), .THR_W(WGT_W)) u_wsc_checker (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .flags(flags),
  .threshold(threshold), .outValid(outValid), .geThreshold(geThreshold)
);

// File: tb/wsc_threshold_cmp_bench.sv
module wsc_threshold_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loadEn = 1'b0;
  logic [7:0]  loadWeight = '0;
  logic        inValid = 1'b0;
  logic [24:0] flags = '0;
  logic [7:0]  threshold = '0;
  logic        outValid, geThreshold;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    bwt [25];
  logic  hV [3];
  logic  hE [3];
  string hT [3];
  logic  held;

  always #2 clk = ~clk;

  wsc_threshold_cmp u_wsc_threshold_cmp (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadWeight(loadWeight),
    .inValid(inValid), .flags(flags), .threshold(threshold),
    .outValid(outValid), .geThreshold(geThreshold)
  );

  function automatic int wsum(input logic [24:0] f);
    int s = 0;
    for (int i = 0; i < 25; i++) if (f[i]) s += bwt[i];
    return s;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // One clock: check the result due now, then drive the next inputs.
  task automatic step(input logic [24:0] f, input int thr, input logic v,
                      input logic le, input logic [7:0] lw, input string tag);
    logic e;
    @(negedge clk);
    if (hV[2]) begin
      check(outValid, 1'b1, hT[2], "outValid");
      check(geThreshold, hE[2], hT[2], "geThreshold");
      held = hE[2];
    end else begin
      check(outValid, 1'b0, "R3", "outValid idle");
      check(geThreshold, held, "R5", "geThreshold hold");
    end
    e = v ? (wsum(f) >= thr) : 1'b0;
    hV[2] = hV[1]; hE[2] = hE[1]; hT[2] = hT[1];
    hV[1] = hV[0]; hE[1] = hE[0]; hT[1] = hT[0];
    hV[0] = v;     hE[0] = e;     hT[0] = tag;
    flags = f; threshold = thr[7:0]; inValid = v;
    loadEn = le; loadWeight = lw;
    if (le) begin
      for (int i = 0; i < 24; i++) bwt[i] = bwt[i+1];
      bwt[24] = int'(lw);
    end
  endtask

  task automatic loadSet(input int mode);
    int w;
    for (int i = 0; i < 25; i++) begin
      if (mode == 0)      w = (i * 7) % 10 + 1;
      else if (mode == 1) w = (i == 0) ? 15 : 10;
      else                w = $urandom % 11;
      step('0, 0, 1'b0, 1'b1, w[7:0], "R7");
    end
  endtask

  initial begin
    int s;
    logic [24:0] f;
    void'($urandom(32'd4711));
    for (int i = 0; i < 25; i++) bwt[i] = 1;
    for (int i = 0; i < 3; i++) begin hV[i] = 0; hE[i] = 0; hT[i] = ""; end
    held = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid, 1'b0, "R1", "reset outValid");
    check(geThreshold, 1'b0, "R1", "reset geThreshold");

    // R1: default weights of 1
    step('1, 25, 1'b1, 1'b0, 8'd0, "R1");
    step('1, 26, 1'b1, 1'b0, 8'd0, "R1");
    step('0, 0, 1'b1, 1'b0, 8'd0, "R6");
    step('0, 3, 1'b1, 1'b0, 8'd0, "R2");
    repeat (4) step('0, 0, 1'b0, 1'b0, 8'd0, "R5");

    // R7: serial load order, probe each cell alone
    loadSet(0);
    for (int k = 0; k < 25; k++) begin
      step(25'(1) << k, bwt[k], 1'b1, 1'b0, 8'd0, "R7");
      step(25'(1) << k, bwt[k] + 1, 1'b1, 1'b0, 8'd0, "R9");
    end

    // R8: loadWeight toggles with loadEn low
    for (int k = 0; k < 40; k++)
      step(25'($urandom), $urandom % 120, 1'b1, 1'b0, 8'($urandom), "R8");

    // R9: exact boundary on random flag sets
    for (int k = 0; k < 20; k++) begin
      f = 25'($urandom);
      s = wsum(f);
      step(f, s, 1'b1, 1'b0, 8'd0, "R9");
      if (s < 255) step(f, s + 1, 1'b1, 1'b0, 8'd0, "R9");
      if (s > 0)   step(f, s - 1, 1'b1, 1'b0, 8'd0, "R9");
    end

    // R10: full total of 255
    loadSet(1);
    step('1, 255, 1'b1, 1'b0, 8'd0, "R10");
    step('1, 0, 1'b1, 1'b0, 8'd0, "R6");
    step(25'h1FFFFFE, 255, 1'b1, 1'b0, 8'd0, "R10");
    step(25'h1FFFFFE, 240, 1'b1, 1'b0, 8'd0, "R10");

    // R2/R4: random back-to-back traffic over random weight sets
    for (int r = 0; r < 3; r++) begin
      loadSet(2);
      for (int k = 0; k < 60; k++)
        step(25'($urandom), $urandom % 140, ($urandom % 4) != 0, 1'b0, 8'd0,
             (k % 2 == 0) ? "R2" : "R4");
    end

    repeat (4) step('0, 0, 1'b0, 1'b0, 8'd0, "R3");
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule